// File: doc/BRIEF.md
# Serial Memory-Mapped Slave with RAM, ROM and Random Source

This block is a serial slave that exposes a tiny read/write memory, a computed read-only table and a pseudo-random byte generator through one 24-bit address space. A host selects the device by pulling chip select low. It then clocks in an opcode and a 24-bit address, and after that it either reads bytes back or writes bytes in. Data moves one bit per clock on a single line, or one nibble per clock on four lines. The address increments after every whole byte until chip select rises.

All protocol logic runs from the serial clock alone. Inputs are sampled on the rising edge, and read data is launched on the falling edge. Chip select high acts as an asynchronous reset of the frame logic. A synchronous reset, taken on the serial clock, clears the RAM and reloads the generator seed. A separate combinational debug port reads any RAM byte for an inspection block.

Top module: `spim_top`

## Requirements
- R1: Opcode 0x03 is a single-line read. The opcode and then a 24-bit address enter MSB first on `dq_in[0]`, one bit per rising edge. From the falling edge that follows the last address bit, each data byte leaves MSB first on `dq_out[1]`, one bit per clock.
- R2: Opcode 0x6B is a quad read. After the address, two turnaround clocks pass with nothing driven. Each byte then leaves as two nibbles on `dq_out[3:0]`, high nibble first, with `dq_out[3]` the nibble MSB.
- R3: Opcode 0x02 is a single-line write. Data bits enter MSB first on `dq_in[0]`. A byte is stored at the rising edge of its eighth bit. A byte left incomplete when chip select rises is discarded.
- R4: Opcode 0x32 is a quad write. Bytes enter as two nibbles on `dq_in[3:0]`, high nibble first.
- R5: After each complete byte, read or write, the address increments by one until chip select rises.
- R6: Pages 0x1xx and 0x3xx both map to the same 8-byte RAM, indexed by address bits [2:0], so the RAM repeats across both pages.
- R7: Page 0x0xx reads table entry i = addr[7:0]. Addresses 0x200–0x243 read entry i = 256 + addr[7:0]. Entry i has the value (29·i + 71) mod 256. Addresses 0x244–0x2FF read 0x00. Writes to these pages change nothing.
- R8: Page 0x4xx reads the state of an 8-bit LFSR with next state {s[6:0], s[7]^s[5]^s[4]^s[3]}. The LFSR advances once after each fully read byte in that page. Writes there do not advance it. Addresses at 0x500 and above read 0x00.
- R9: `dq_oe` is 4'b0010 during a single-read data phase, 4'b1111 during a quad-read data phase, and 4'b0000 otherwise. Chip select high clears it at once and returns the frame logic to opcode reception.
- R10: Any other opcode makes the rest of the frame ignored: nothing is driven and nothing is stored.
- R11: `rst` high at a rising serial clock edge clears all RAM bytes to 0x00 and loads the LFSR with 0xA5.
- R12: `dbg_data` shows the RAM byte at index `dbg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; the only clock |
| rst | input | 1 | Synchronous active-high reset on sclk rising edge |
| csn | input | 1 | Active-low chip select; high resets the frame |
| dq_in | input | 4 | Data lines in; bit 0 carries opcode, address and single-line writes |
| dq_out | output | 4 | Data lines out; bit 1 carries single-line read data |
| dq_oe | output | 4 | Per-line output enable |
| dbg_addr | input | 3 | RAM index for the debug port |
| dbg_data | output | 8 | RAM byte at dbg_addr |

## Verification
For a single read, the first data bit appears on the falling edge after the 32nd rising edge of the frame. For a quad read, it appears two falling edges later. Each later bit or nibble arrives one falling edge after the one before. A written byte shows on the debug port right after the rising edge that takes its last bit. The bench drives inputs 1 ns after each falling edge and samples outputs 3 ns after it, so every sample sees the value the host would capture on the next rising edge. Expected bytes are queued in address order before a read starts, and the monitor compares them one by one as the bits come in.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W    = 24;
    localparam int PAGE_W    = ADDR_W - 8;
    localparam int CNT_W     = $clog2(ADDR_W);
    localparam int TURN_CYC  = 2;

    localparam logic [7:0] OP_RD1 = 8'h03;
    localparam logic [7:0] OP_WR1 = 8'h02;
    localparam logic [7:0] OP_RD4 = 8'h6B;
    localparam logic [7:0] OP_WR4 = 8'h32;

    localparam logic [PAGE_W-1:0] PG_BOOT = PAGE_W'(0);
    localparam logic [PAGE_W-1:0] PG_RAM  = PAGE_W'(1);
    localparam logic [PAGE_W-1:0] PG_PROG = PAGE_W'(2);
    localparam logic [PAGE_W-1:0] PG_MIRR = PAGE_W'(3);
    localparam logic [PAGE_W-1:0] PG_RAND = PAGE_W'(4);

    localparam logic [7:0] ROM_MUL = 8'd29;
    localparam logic [7:0] ROM_ADD = 8'd71;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_TURN, ST_RD, ST_WR, ST_IGN
    } state_e;

    typedef enum logic [2:0] {
        RG_BOOT, RG_RAM, RG_PROG, RG_RAND, RG_NONE
    } region_e;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic quad;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [7:0] op);
        cmd_s c;
        c = '0;
        case (op)
            OP_RD1:  begin c.valid = 1'b1; c.is_read = 1'b1; end
            OP_WR1:  begin c.valid = 1'b1; end
            OP_RD4:  begin c.valid = 1'b1; c.is_read = 1'b1; c.quad = 1'b1; end
            OP_WR4:  begin c.valid = 1'b1; c.quad = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] pg;
        pg = a[ADDR_W-1:8];
        if (pg == PG_BOOT)                      return RG_BOOT;
        else if (pg == PG_RAM || pg == PG_MIRR) return RG_RAM;
        else if (pg == PG_PROG)                 return RG_PROG;
        else if (pg == PG_RAND)                 return RG_RAND;
        else                                    return RG_NONE;
    endfunction

    function automatic logic [7:0] rom_value(input logic [15:0] idx);
        logic [15:0] p;
        p = idx * {8'd0, ROM_MUL} + {8'd0, ROM_ADD};
        return p[7:0];
    endfunction

endpackage

// File: rtl/spim_lfsr.sv
module spim_lfsr #(
    parameter int         W    = 8,
    parameter logic [W-1:0] SEED = 8'hA5,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state
);

    logic fb;
    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (step)
            state <= {state[W-2:0], fb};
    end

    // R8
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state));

    // R8
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (state != $past(state)));

endmodule

// File: rtl/spim_store.sv
module spim_store
    import spim_pkg::*;
#(
    parameter int BOOT_LEN  = 256,
    parameter int PROG_LEN  = 68,
    parameter int RAM_DEPTH = 8,
    parameter logic [7:0] SEED = 8'hA5,
    parameter logic [7:0] TAPS = 8'hB8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_adv,
    output logic [7:0]                    rd_data,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [7:0]                    wr_data,
    input  logic [$clog2(RAM_DEPTH)-1:0]  dbg_addr,
    output logic [7:0]                    dbg_data
);

    localparam int RAM_AW  = $clog2(RAM_DEPTH);
    localparam int ROM_LEN = BOOT_LEN + PROG_LEN;
    localparam int ROM_IW  = $clog2(ROM_LEN);

    logic [RAM_DEPTH-1:0][7:0] mem;
    logic [RAM_DEPTH-1:0]      cell_we;
    logic [7:0]                rnd;
    region_e                   rd_rg;
    region_e                   wr_rg;
    logic                      wr_hit;
    logic [RAM_AW-1:0]         wr_idx;
    logic                      rom_ok;
    logic [ROM_IW-1:0]         rom_idx;

    assign rd_rg  = region_of(rd_addr);
    assign wr_rg  = region_of(wr_addr);
    assign wr_hit = wr_en && (wr_rg == RG_RAM);
    assign wr_idx = wr_addr[RAM_AW-1:0];

    for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_we
        assign cell_we[g] = wr_hit && (wr_idx == RAM_AW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < RAM_DEPTH; i++) begin
            if (rst)
                mem[i] <= 8'h00;
            else if (cell_we[i])
                mem[i] <= wr_data;
        end
    end

    spim_lfsr #(.W(8), .SEED(SEED), .TAPS(TAPS)) u_rng (
        .clk   (clk),
        .rst   (rst),
        .step  (rd_adv && (rd_rg == RG_RAND)),
        .state (rnd)
    );

    always_comb begin
        rom_ok  = 1'b0;
        rom_idx = '0;
        if (rd_rg == RG_BOOT && int'(rd_addr[7:0]) < BOOT_LEN) begin
            rom_ok  = 1'b1;
            rom_idx = ROM_IW'(int'(rd_addr[7:0]));
        end else if (rd_rg == RG_PROG && int'(rd_addr[7:0]) < PROG_LEN) begin
            rom_ok  = 1'b1;
            rom_idx = ROM_IW'(BOOT_LEN + int'(rd_addr[7:0]));
        end
    end

    always_comb begin
        case (rd_rg)
            RG_RAM:           rd_data = mem[rd_addr[RAM_AW-1:0]];
            RG_RAND:          rd_data = rnd;
            RG_BOOT, RG_PROG: rd_data = rom_ok ? rom_value(16'(rom_idx)) : 8'h00;
            default:          rd_data = 8'h00;
        endcase
    end

    assign dbg_data = mem[dbg_addr];

    // R7
    rom_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_rg != RG_RAM) |=> $stable(mem));

    // R6
    ram_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/spim_proto.sv
module spim_proto
    import spim_pkg::*;
(
    input  logic              sclk,
    input  logic              csn,
    input  logic              rst,
    input  logic [3:0]        din,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_adv,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe
);

    state_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic              quad;
    logic              is_rd;
    logic              byte_last;
    logic [7:0]        cmd_now;
    logic [ADDR_W-1:0] addr_now;
    cmd_s              cmd_dec;
    logic [2:0]        bit_sel;
    logic [3:0]        nib;

    assign cmd_now   = {shreg[6:0], din[0]};
    assign addr_now  = {shreg[ADDR_W-2:0], din[0]};
    assign cmd_dec   = decode_cmd(cmd_now);
    assign byte_last = quad ? (cnt == CNT_W'(1)) : (cnt == CNT_W'(7));

    assign rd_addr = addr;
    assign wr_addr = addr;
    assign rd_adv  = (state == ST_RD) && byte_last;
    assign wr_en   = (state == ST_WR) && byte_last;
    assign wr_data = quad ? {shreg[3:0], din} : {shreg[6:0], din[0]};

    always_ff @(posedge sclk or posedge csn) begin
        if (csn) begin
            state <= ST_CMD;
            cnt   <= '0;
            shreg <= '0;
            addr  <= '0;
            quad  <= 1'b0;
            is_rd <= 1'b0;
        end else if (rst) begin
            state <= ST_CMD;
            cnt   <= '0;
            shreg <= '0;
            addr  <= '0;
            quad  <= 1'b0;
            is_rd <= 1'b0;
        end else begin
            case (state)
                ST_CMD: begin
                    shreg <= addr_now;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_W'(7)) begin
                        cnt   <= '0;
                        quad  <= cmd_dec.quad;
                        is_rd <= cmd_dec.is_read;
                        state <= cmd_dec.valid ? ST_ADDR : ST_IGN;
                    end
                end
                ST_ADDR: begin
                    shreg <= addr_now;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_W'(ADDR_W - 1)) begin
                        cnt  <= '0;
                        addr <= addr_now;
                        if (!is_rd)
                            state <= ST_WR;
                        else if (quad)
                            state <= ST_TURN;
                        else
                            state <= ST_RD;
                    end
                end
                ST_TURN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(TURN_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_RD;
                    end
                end
                ST_RD: begin
                    cnt <= cnt + 1'b1;
                    if (byte_last) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                    end
                end
                ST_WR: begin
                    shreg <= quad ? {shreg[ADDR_W-5:0], din} : addr_now;
                    cnt   <= cnt + 1'b1;
                    if (byte_last) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                    end
                end
                default: state <= ST_IGN;
            endcase
        end
    end

    assign bit_sel = 3'(7 - int'(cnt));
    assign nib     = (cnt == '0) ? rd_data[7:4] : rd_data[3:0];

    always_ff @(negedge sclk or posedge csn) begin
        if (csn) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else if (rst || state != ST_RD) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else if (quad) begin
            dq_out <= nib;
            dq_oe  <= 4'b1111;
        end else begin
            dq_out <= {2'b00, rd_data[bit_sel], 1'b0};
            dq_oe  <= 4'b0010;
        end
    end

    // R9
    oe_read_only_chk: assert property (@(posedge sclk) disable iff (csn || rst)
        (dq_oe != 4'b0000) |-> (state == ST_RD));

    // R2
    turn_len_chk: assert property (@(posedge sclk) disable iff (csn || rst)
        (state == ST_RD && $past(state) == ST_TURN) |-> ($past(state, 2) == ST_TURN));

    // R1
    cmd_len_chk: assert property (@(posedge sclk) disable iff (csn || rst)
        (state == ST_ADDR && $past(state) == ST_CMD) |-> ($past(cnt) == CNT_W'(7)));

    // R5
    addr_step_chk: assert property (@(posedge sclk) disable iff (csn || rst)
        (rd_adv || wr_en) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int BOOT_LEN  = 256,
    parameter int PROG_LEN  = 68,
    parameter int RAM_DEPTH = 8,
    parameter logic [7:0] SEED = 8'hA5,
    parameter logic [7:0] TAPS = 8'hB8,
    localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              csn,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic [RAM_AW-1:0] dbg_addr,
    output logic [7:0]        dbg_data
);

    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_adv;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;

    spim_proto u_proto (
        .sclk    (sclk),
        .csn     (csn),
        .rst     (rst),
        .din     (dq_in),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .rd_adv  (rd_adv),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    spim_store #(
        .BOOT_LEN  (BOOT_LEN),
        .PROG_LEN  (PROG_LEN),
        .RAM_DEPTH (RAM_DEPTH),
        .SEED      (SEED),
        .TAPS      (TAPS)
    ) u_store (
        .clk      (sclk),
        .rst      (rst),
        .rd_addr  (rd_addr),
        .rd_adv   (rd_adv),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

endmodule

// File: tb/spim_top_test.sv
module spim_top_test;

    logic       sclk = 1'b0;
    logic       rst;
    logic       csn;
    logic [3:0] dq_in;
    logic [3:0] dq_out;
    logic [3:0] dq_oe;
    logic [2:0] dbg_addr;
    logic [7:0] dbg_data;

    always #4 sclk = ~sclk;

    spim_top uut (
        .sclk     (sclk),
        .rst      (rst),
        .csn      (csn),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] ram_m [8];
    logic [7:0] lfsr_m;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] pay_q [$];
    logic       mon_active = 1'b0;
    logic       mon_quad   = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [7:0] model_byte(input logic [23:0] a);
        logic [7:0] r;
        int idx;
        r = 8'h00;
        case (a[23:8])
            16'h0000: begin idx = int'(a[7:0]); r = 8'((idx * 29 + 71) % 256); end
            16'h0002: if (a[7:0] < 8'd68) begin idx = 256 + int'(a[7:0]); r = 8'((idx * 29 + 71) % 256); end
            16'h0001, 16'h0003: r = ram_m[a[2:0]];
            16'h0004: begin r = lfsr_m; lfsr_m = lfsr_next(lfsr_m); end
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic header(input logic [7:0] op, input logic [23:0] a);
        logic [31:0] w;
        w = {op, a};
        for (int i = 0; i < 32; i++) begin
            @(negedge sclk); #1;
            csn   = 1'b0;
            dq_in = {3'b000, w[31-i]};
        end
    endtask

    task automatic finish_frame();
        @(negedge sclk); #1;
        mon_active = 1'b0;
        csn   = 1'b1;
        dq_in = 4'h0;
        @(negedge sclk);
    endtask

    task automatic do_write(input bit quad, input logic [23:0] a0);
        logic [23:0] a;
        logic [7:0]  b;
        a = a0;
        header(quad ? 8'h32 : 8'h02, a);
        while (pay_q.size() > 0) begin
            b = pay_q.pop_front();
            if (quad) begin
                @(negedge sclk); #1; dq_in = b[7:4];
                @(negedge sclk); #1; dq_in = b[3:0];
            end else begin
                for (int k = 7; k >= 0; k--) begin
                    @(negedge sclk); #1; dq_in = {3'b000, b[k]};
                end
            end
            if (a[23:8] == 16'h0001 || a[23:8] == 16'h0003)
                ram_m[a[2:0]] = b;
            a = a + 1'b1;
        end
        finish_frame();
    endtask

    task automatic do_read(input bit quad, input logic [23:0] a0, input int n, input string tag);
        logic [23:0] a;
        a = a0;
        header(quad ? 8'h6B : 8'h03, a);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model_byte(a));
            tag_q.push_back(tag);
            a = a + 1'b1;
        end
        if (quad) repeat (2) @(negedge sclk);
        for (int s = 0; s < n * (quad ? 2 : 8); s++) begin
            @(negedge sclk); #1;
            mon_quad   = quad;
            mon_active = 1'b1;
        end
        finish_frame();
    endtask

    task automatic check_ram(input string req);
        for (int i = 0; i < 8; i++) begin
            dbg_addr = 3'(i);
            #1;
            check(dbg_data === ram_m[i], req, {24'h0, dbg_data}, {24'h0, ram_m[i]});
        end
    endtask

    // Monitor: pops one expected byte per completed received byte
    initial begin
        logic [7:0] acc;
        int         nbits;
        bit         oe_ok;
        logic [3:0] exp_oe;
        logic [7:0] e;
        string      t;
        acc = 0; nbits = 0; oe_ok = 1'b1;
        forever begin
            @(negedge sclk); #3;
            if (!mon_active) begin
                nbits = 0; acc = 0; oe_ok = 1'b1;
            end else begin
                exp_oe = mon_quad ? 4'b1111 : 4'b0010;
                if (dq_oe !== exp_oe) oe_ok = 1'b0;
                if (mon_quad) begin acc = {acc[3:0], dq_out}; nbits += 4; end
                else          begin acc = {acc[6:0], dq_out[1]}; nbits += 1; end
                if (nbits == 8) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected byte", {24'h0, acc}, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(acc === e, t, {24'h0, acc}, {24'h0, e});
                    end
                    check(oe_ok, "R9 read enables", {28'h0, dq_oe}, {28'h0, exp_oe});
                    nbits = 0; oe_ok = 1'b1;
                end
            end
        end
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen_oe;
        rst = 1'b1; csn = 1'b1; dq_in = 4'h0; dbg_addr = 3'd0;
        for (int i = 0; i < 8; i++) ram_m[i] = 8'h00;
        lfsr_m = 8'hA5;
        repeat (4) @(negedge sclk);
        #1 rst = 1'b0;
        @(negedge sclk); #2;

        // R9 / R11 reset state
        check(dq_oe === 4'h0, "R9 idle enables", {28'h0, dq_oe}, 32'h0);
        check_ram("R11 reset RAM");

        // R3 single write, R12 debug view
        pay_q = '{8'h11, 8'h22, 8'h33};
        do_write(1'b0, 24'h000101);
        check_ram("R3 single write / R12 debug");

        // R4 quad write through mirror page, wraps low bits
        pay_q = '{8'hAA, 8'hBB, 8'hCC};
        do_write(1'b1, 24'h000306);
        check_ram("R4 quad write / R6 wrap");

        // R1 single read
        do_read(1'b0, 24'h000102, 2, "R1 single read");
        // R5 auto-increment across RAM wrap, R6 repeat
        do_read(1'b0, 24'h000100, 9, "R5 R6 sequential RAM");
        // R2 quad read via mirror
        do_read(1'b1, 24'h0003FE, 2, "R2 quad read mirror");

        // R7 table reads
        do_read(1'b0, 24'h0000FD, 3, "R7 boot table");
        do_read(1'b1, 24'h00023E, 8, "R7 second table end");

        // R7 writes to table ignored
        pay_q = '{8'h5A};
        do_write(1'b0, 24'h000200);
        do_read(1'b0, 24'h000200, 1, "R7 write ignored");

        // R8 random page
        do_read(1'b1, 24'h000400, 3, "R8 random quad");
        pay_q = '{8'h55};
        do_write(1'b1, 24'h000410);
        do_read(1'b0, 24'h0004FF, 2, "R8 random then empty");

        // R3 partial byte discarded
        header(8'h02, 24'h000100);
        for (int k = 7; k >= 0; k--) begin
            @(negedge sclk); #1; dq_in = {3'b000, 8'h5C >> k};
        end
        repeat (4) begin @(negedge sclk); #1; dq_in = 4'h1; end
        finish_frame();
        ram_m[0] = 8'h5C;
        check_ram("R3 partial byte");

        // R10 unknown opcode
        seen_oe = 1'b0;
        header(8'h9F, 24'h000101);
        for (int s = 0; s < 16; s++) begin
            @(negedge sclk); #1; dq_in = 4'hF;
            #2; if (dq_oe !== 4'h0) seen_oe = 1'b1;
        end
        finish_frame();
        check(!seen_oe, "R10 no drive on bad opcode", {31'h0, seen_oe}, 32'h0);
        check_ram("R10 no store on bad opcode");

        // R9 chip select aborts mid read
        header(8'h03, 24'h000100);
        repeat (4) @(negedge sclk);
        @(negedge sclk); #1; csn = 1'b1;
        #2;
        check(dq_oe === 4'h0, "R9 abort clears enables", {28'h0, dq_oe}, 32'h0);
        @(negedge sclk);
        do_read(1'b0, 24'h000101, 1, "R9 restart after abort");

        // R11 reset clears RAM, reloads seed
        @(negedge sclk); #1 rst = 1'b1;
        repeat (2) @(negedge sclk);
        #1 rst = 1'b0;
        for (int i = 0; i < 8; i++) ram_m[i] = 8'h00;
        lfsr_m = 8'hA5;
        @(negedge sclk); #2;
        check_ram("R11 RAM cleared");
        do_read(1'b0, 24'h000400, 1, "R11 seed reloaded");

        repeat (4) @(negedge sclk);
        check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule